// File: doc/BRIEF.md
# Register Group Beat Sequencer

A vector operation may name a group of one, two, four or eight architectural registers through a single base index. When that group holds more bits than the physical datapath carries in one cycle, the operation has to be split into several datapath-wide beats. This block takes one such operation and produces those beats. An operation is described by a base register, a group-size code, an element-width code and a granted element count.

On acceptance the base index is checked against the group size. A misaligned base produces a one-cycle error pulse and no beats. An aligned operation produces an ascending sequence of beats. Each beat names its first physical register and the index of its first element. The sequence stops early once a beat would start at or past the granted element count, and the final beat carries a last flag. Beats leave through a valid/ready handshake. A new operation is taken only when the previous one has fully drained.

The register length and datapath width are parameters, and the datapath must be at least one register wide. With the defaults of 128-bit registers and a 256-bit datapath, each beat spans two registers.

Top module: `gbs_beat_sequencer`

## Requirements
- R1: After reset, `beat_valid` and `err_pulse` are low and `req_ready` is high.
- R2: A request whose base index is not a multiple of the group size is accepted. `err_pulse` is high for exactly the one cycle after acceptance, no beat is issued, and `req_ready` stays high.
- R3: The group size is 2 to the power of `req_grp`, so codes 0, 1, 2 and 3 select 1, 2, 4 and 8 registers. Any base that is a multiple of the group size among the 32 registers is legal. For a size of 8, these are 0, 8, 16 and 24.
- R4: The number of beats in a full group is the larger of 1 and group size × REG_BITS ÷ DP_BITS. Each beat spans the smaller of the group size and DP_BITS ÷ REG_BITS registers. Beat k reports `beat_reg` = base + k × that span, so the lower registers come first.
- R5: The element width is 8 shifted left by `req_ew` bits (codes 0 to 3 give 8, 16, 32 and 64 bits). Beat k reports `beat_elem` = k × span × (REG_BITS ÷ element width).
- R6: A beat whose starting element is at or beyond `req_vl` is not issued. A request with `req_vl` = 0 issues no beats, and `req_ready` stays high.
- R7: `beat_last` is high on the final issued beat and low on every earlier one.
- R8: While `beat_valid` is high and `beat_ready` is low, `beat_reg`, `beat_elem` and `beat_last` hold their values and `beat_valid` stays high.
- R9: `req_ready` is low from the cycle after acceptance until the last beat's handshake. Requests presented in that window have no effect on the beats. `req_ready` is high again in the cycle after that handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_base | input | 5 | Base architectural register index |
| req_grp | input | 2 | Group-size code (size = 2^code) |
| req_ew | input | 2 | Element-width code (8 << code bits) |
| req_vl | input | VL_W (8) | Granted element count |
| err_pulse | output | 1 | One-cycle illegal-base indication |
| beat_valid | output | 1 | Beat available |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_reg | output | 5 | First physical register of the beat |
| beat_elem | output | VL_W (8) | Index of the first element in the beat |
| beat_last | output | 1 | Final issued beat of the operation |

## Verification
Every group size is run over a full group. This separates the single-beat cases (groups of one and two registers) from the multi-beat cases (four and eight registers), and shows that the register stride differs from the element stride. Element widths of 8, 32 and 64 bits change only the element offsets, which shows that the element scaling is independent of the register stride. Granted counts of zero, a mid-group value, an exact multiple and an oversize value test the truncation and last-flag logic at each of its edges. Misaligned bases, a stalling consumer and requests arriving mid-operation show that the handshake and the alignment check keep the beats intact.

// File: rtl/gbs_pkg.sv
package gbs_pkg;

    localparam int unsigned ARCH_REGS   = 32;
    localparam int unsigned REG_IDX_W   = $clog2(ARCH_REGS);
    localparam int unsigned MAX_GRP_LOG = 3;
    localparam int unsigned BEAT_IDX_W  = MAX_GRP_LOG;

    typedef enum logic [1:0] {
        GRP_X1 = 2'd0,
        GRP_X2 = 2'd1,
        GRP_X4 = 2'd2,
        GRP_X8 = 2'd3
    } grp_e;

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } ew_e;

    typedef struct packed {
        logic [REG_IDX_W-1:0] base;
        grp_e                 grp;
        ew_e                  ew;
    } op_cfg_t;

    typedef struct packed {
        logic [REG_IDX_W-1:0] first_reg;
        logic                 last;
    } beat_info_t;

    function automatic logic base_misaligned(input logic [REG_IDX_W-1:0] base,
                                             input grp_e grp);
        logic [REG_IDX_W-1:0] mask;
        mask = REG_IDX_W'((32'd1 << 32'(grp)) - 32'd1);
        return (base & mask) != '0;
    endfunction

    function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/gbs_align_chk.sv
module gbs_align_chk
    import gbs_pkg::*;
(
    input  op_cfg_t cfg,
    output logic    illegal
);
    always_comb begin
        illegal = base_misaligned(cfg.base, cfg.grp);
    end
endmodule

// File: rtl/gbs_beat_plan.sv
module gbs_beat_plan
    import gbs_pkg::*;
#(
    parameter int unsigned REG_BITS = 128,
    parameter int unsigned DP_BITS  = 256,
    parameter int unsigned VL_W     = 8
) (
    input  op_cfg_t                cfg,
    input  logic [VL_W-1:0]        vl,
    input  logic [BEAT_IDX_W-1:0]  idx,
    output beat_info_t             info,
    output logic [VL_W-1:0]        elem
);
    localparam int unsigned SPAN_LOG_MAX = $clog2(DP_BITS / REG_BITS);
    localparam int unsigned EPR8_LOG     = $clog2(REG_BITS / 8);

    int unsigned grp_log;
    int unsigned span_log;
    int unsigned ew_log;
    int unsigned beats;
    int unsigned start;
    int unsigned next_start;

    always_comb begin
        grp_log    = 32'(cfg.grp);
        span_log   = min_u(grp_log, SPAN_LOG_MAX);
        ew_log     = EPR8_LOG - 32'(cfg.ew);
        beats      = 32'd1 << (grp_log - span_log);
        start      = 32'(idx) << (span_log + ew_log);
        next_start = (32'(idx) + 32'd1) << (span_log + ew_log);

        info.first_reg = REG_IDX_W'(32'(cfg.base) + (32'(idx) << span_log));
        info.last      = ((32'(idx) + 32'd1) == beats) || (next_start >= 32'(vl));
        elem           = VL_W'(start);
    end
endmodule

// File: rtl/gbs_seq_ctrl.sv
module gbs_seq_ctrl
    import gbs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_fire,
    input  logic                  illegal,
    input  logic                  vl_zero,
    input  logic                  beat_ready,
    input  logic                  beat_last,
    output logic                  busy,
    output logic [BEAT_IDX_W-1:0] idx,
    output logic                  err
);
    logic                  busy_q;
    logic [BEAT_IDX_W-1:0] idx_q;
    logic                  err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= req_fire && illegal;
            if (!busy_q) begin
                idx_q <= '0;
                if (req_fire && !illegal && !vl_zero) begin
                    busy_q <= 1'b1;
                end
            end else if (beat_ready) begin
                if (beat_last) begin
                    busy_q <= 1'b0;
                    idx_q  <= '0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign idx  = idx_q;
    assign err  = err_q;

    // R2: an error pulse never coincides with an issued beat
    assert_err_no_beat_R2: assert property (@(posedge clk) disable iff (rst)
        err_q |-> !busy_q);

    // R8: a stalled beat keeps its position in the sequence
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !beat_ready) |=> (busy_q && $stable(idx_q)));

    // R7: the last handshake ends the operation
    assert_last_ends_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_q && beat_ready && beat_last) |=> !busy_q);

    // R9: an operation is not dropped before its last handshake
    assert_no_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !(beat_ready && beat_last)) |=> busy_q);
endmodule

// File: rtl/gbs_beat_sequencer.sv
module gbs_beat_sequencer
    import gbs_pkg::*;
#(
    parameter int unsigned REG_BITS = 128,
    parameter int unsigned DP_BITS  = 256,
    parameter int unsigned VL_W     = $clog2(REG_BITS / 8) + MAX_GRP_LOG + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [REG_IDX_W-1:0] req_base,
    input  logic [1:0]           req_grp,
    input  logic [1:0]           req_ew,
    input  logic [VL_W-1:0]      req_vl,
    output logic                 err_pulse,
    output logic                 beat_valid,
    input  logic                 beat_ready,
    output logic [REG_IDX_W-1:0] beat_reg,
    output logic [VL_W-1:0]      beat_elem,
    output logic                 beat_last
);
    initial begin
        if (DP_BITS < REG_BITS || REG_BITS < 64) begin
            $error("datapath must be at least one register wide, register at least 64 bits");
        end
    end

    op_cfg_t                req_cfg;
    op_cfg_t                cfg_q;
    logic [VL_W-1:0]        vl_q;
    logic                   illegal;
    logic                   busy;
    logic                   req_fire;
    logic [BEAT_IDX_W-1:0]  idx;
    beat_info_t             info;
    logic [VL_W-1:0]        elem;

    always_comb begin
        req_cfg.base = req_base;
        req_cfg.grp  = grp_e'(req_grp);
        req_cfg.ew   = ew_e'(req_ew);
    end

    assign req_ready = !busy;
    assign req_fire  = req_valid && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            vl_q  <= '0;
        end else if (req_fire) begin
            cfg_q <= req_cfg;
            vl_q  <= req_vl;
        end
    end

    gbs_align_chk u_align (
        .cfg     (req_cfg),
        .illegal (illegal)
    );

    gbs_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_fire   (req_fire),
        .illegal    (illegal),
        .vl_zero    (req_vl == '0),
        .beat_ready (beat_ready),
        .beat_last  (info.last),
        .busy       (busy),
        .idx        (idx),
        .err        (err_pulse)
    );

    gbs_beat_plan #(
        .REG_BITS (REG_BITS),
        .DP_BITS  (DP_BITS),
        .VL_W     (VL_W)
    ) u_plan (
        .cfg  (cfg_q),
        .vl   (vl_q),
        .idx  (idx),
        .info (info),
        .elem (elem)
    );

    assign beat_valid = busy;
    assign beat_reg   = info.first_reg;
    assign beat_elem  = elem;
    assign beat_last  = info.last;

    // R8: beat fields hold under back-pressure
    assert_beat_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_ready) |=>
            (beat_valid && $stable(beat_reg) && $stable(beat_elem) && $stable(beat_last)));

    // R6: no issued beat starts at or past the granted count
    assert_elem_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> (32'(beat_elem) < 32'(vl_q)));

    // R6: a zero count issues nothing
    assert_zero_vl_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_vl == '0) |=> !beat_valid);

    // R5: element offsets strictly rise from beat to beat
    assert_elem_rises_R5: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_ready && !beat_last) |=> (beat_elem > $past(beat_elem)));
endmodule

// File: tb/tb_gbs_beat_sequencer.sv
module tb_gbs_beat_sequencer;
    localparam int REG_BITS = 128;
    localparam int DP_BITS  = 256;
    localparam int VL_W     = 8;

    logic            clk = 1'b0;
    logic            rst;
    logic            req_valid;
    logic            req_ready;
    logic [4:0]      req_base;
    logic [1:0]      req_grp;
    logic [1:0]      req_ew;
    logic [VL_W-1:0] req_vl;
    logic            err_pulse;
    logic            beat_valid;
    logic            beat_ready;
    logic [4:0]      beat_reg;
    logic [VL_W-1:0] beat_elem;
    logic            beat_last;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    gbs_beat_sequencer #(.REG_BITS(REG_BITS), .DP_BITS(DP_BITS)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_grp(req_grp), .req_ew(req_ew), .req_vl(req_vl),
        .err_pulse(err_pulse), .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_reg(beat_reg), .beat_elem(beat_elem), .beat_last(beat_last)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int span_of(input int grp);
        int g = 1 << grp;
        return (g < DP_BITS / REG_BITS) ? g : DP_BITS / REG_BITS;
    endfunction

    function automatic int beats_issued(input int grp, input int ew, input int vl);
        int full = ((1 << grp) * REG_BITS) / DP_BITS;
        int step = span_of(grp) * (REG_BITS / (8 << ew));
        int n = 0;
        if (full < 1) full = 1;
        for (int k = 0; k < full; k++) if (k * step < vl) n++;
        return n;
    endfunction

    task automatic send(input int base, input int grp, input int ew, input int vl);
        @(negedge clk);
        req_valid = 1'b1;
        req_base  = 5'(base);
        req_grp   = 2'(grp);
        req_ew    = 2'(ew);
        req_vl    = VL_W'(vl);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic consume(input string tag, input int base, input int grp, input int ew,
                           input int vl, input bit stall);
        int n     = beats_issued(grp, ew, vl);
        int span  = span_of(grp);
        int step  = span * (REG_BITS / (8 << ew));
        int k     = 0;
        int guard = 0;
        if (n == 0) begin
            chk(!beat_valid, {tag, " R6 no beat"}, int'(beat_valid), 0);
            chk(req_ready, {tag, " R6 ready"}, int'(req_ready), 1);
            return;
        end
        while (k < n && guard < 100) begin
            bit rdy = stall ? (guard % 3 == 2) : 1'b1;
            chk(beat_valid, {tag, " R8 valid"}, int'(beat_valid), 1);
            chk(req_ready == 1'b0, {tag, " R9 busy"}, int'(req_ready), 0);
            chk(beat_reg == 5'(base + k * span), {tag, " R4 reg"}, int'(beat_reg), base + k * span);
            chk(beat_elem == VL_W'(k * step), {tag, " R5 elem"}, int'(beat_elem), k * step);
            chk(beat_last == (k == n - 1), {tag, " R7 last"}, int'(beat_last), int'(k == n - 1));
            beat_ready = rdy;
            @(negedge clk);
            if (rdy) k++;
            guard++;
        end
        beat_ready = 1'b0;
        chk(!beat_valid, {tag, " R7 end"}, int'(beat_valid), 0);
        chk(req_ready, {tag, " R9 ready again"}, int'(req_ready), 1);
    endtask

    task automatic run_op(input string tag, input int base, input int grp, input int ew,
                          input int vl, input bit stall);
        send(base, grp, ew, vl);
        consume(tag, base, grp, ew, vl, stall);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        req_valid = 1'b0; beat_ready = 1'b0;
        req_base = '0; req_grp = '0; req_ew = '0; req_vl = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!beat_valid, "R1 valid", int'(beat_valid), 0);
        chk(req_ready, "R1 ready", int'(req_ready), 1);
        chk(!err_pulse, "R1 err", int'(err_pulse), 0);
    endtask

    task automatic t_misaligned(input int base, input int grp);
        send(base, grp, 2, 32);
        chk(err_pulse, "R2 pulse", int'(err_pulse), 1);
        chk(!beat_valid, "R2 no beat", int'(beat_valid), 0);
        chk(req_ready, "R2 ready", int'(req_ready), 1);
        @(negedge clk);
        chk(!err_pulse, "R2 pulse width", int'(err_pulse), 0);
        chk(!beat_valid, "R2 still no beat", int'(beat_valid), 0);
    endtask

    task automatic t_busy_ignore;
        send(8, 3, 2, 32);
        req_valid = 1'b1; req_base = 5'd0; req_grp = 2'd0; req_ew = 2'd0; req_vl = 8'd1;
        for (int i = 0; i < 3; i++) begin
            chk(!req_ready, "R9 not ready while busy", int'(req_ready), 0);
            chk(beat_reg == 5'd8, "R9 beat unaffected", int'(beat_reg), 8);
            @(negedge clk);
        end
        req_valid = 1'b0;
        consume("busy", 8, 3, 2, 32, 1'b0);
        @(negedge clk);
        chk(!beat_valid && !err_pulse, "R9 no stray op", int'(beat_valid), 0);
    endtask

    initial begin
        t_reset();
        run_op("x4 base4 e32", 4, 2, 2, 16, 1'b0);
        run_op("x8 base8 e32", 8, 3, 2, 32, 1'b0);
        run_op("x8 base24 vl10", 24, 3, 2, 10, 1'b0);
        run_op("x8 base16 vl exact", 16, 3, 2, 16, 1'b0);
        run_op("x1 base5", 5, 0, 2, 4, 1'b0);
        run_op("x2 base2", 2, 1, 2, 8, 1'b0);
        run_op("x4 base0 e8", 0, 2, 0, 64, 1'b0);
        run_op("x8 base0 e64 R3", 0, 3, 3, 16, 1'b0);
        run_op("x1 oversize vl", 31, 0, 3, 255, 1'b0);
        run_op("vl zero", 0, 2, 2, 0, 1'b0);
        run_op("stall R8", 8, 3, 2, 32, 1'b1);
        t_misaligned(6, 2);
        t_misaligned(12, 3);
        t_misaligned(1, 1);
        t_busy_ignore();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule